// File: doc/BRIEF.md
# Column Line Latch and Four-Level Drive Selector

This block sits between a column shift loader and the analog output stage of a dot-matrix display column driver. The loader fills a shadow register with one bit per column. When the latch pulse falls, the block copies the whole shadow register into a line register in one step. Loading of the next line can then go on while the current line is being shown.

For every column, the block produces a 2-bit code that names one of four drive levels. From highest to lowest, these levels are V0, V2, V3 and V5. The code is chosen from three things: the column's latched bit, a frame-polarity input that flips the drive waveform on alternate frames, and an active-low display-enable input. When display-enable is low, every column is forced to the lowest level. The frame and enable inputs act on the codes combinationally. Only the line data waits for a latch pulse.

The latch pulse is sampled on the block clock. A falling edge is seen when one sample is high and the next sample is low. Level shifting and the analog output switches are handled outside this block.

Top module: `lcdlvl_top`

## Requirements
- R1: When `lp_i` is sampled high on one rising clock edge and low on the next, all columns of `shadow_i` are copied into the line register at that second edge. The new codes appear after that edge.
- R2: Whenever R1's falling-edge condition is not met, the line register keeps its value. This covers `lp_i` held low, `lp_i` held high and a rising `lp_i`. Changes on `shadow_i` in that time have no effect on `level_o`.
- R3: When `blank_ni` is 1 and `frame_i` is 1, a column whose latched bit is 1 shows code 2'b00 (V0), and a column whose latched bit is 0 shows code 2'b01 (V2).
- R4: When `blank_ni` is 1 and `frame_i` is 0, a column whose latched bit is 1 shows code 2'b11 (V5), and a column whose latched bit is 0 shows code 2'b10 (V3).
- R5: When `blank_ni` is 0, every column shows code 2'b11 (V5), whatever the latched data or `frame_i` may be.
- R6: Changes on `frame_i` and `blank_ni` reach `level_o` without a clock edge. They neither alter the line register nor block a capture.
- R7: While `rst_ni` is low, the line register is cleared to all zeros.
- R8: Column i takes shadow bit i, and its code sits at `level_o[2*i+1:2*i]`. This holds for column 0 and for the last column alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; `lp_i` is sampled on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| lp_i | input | 1 | Latch pulse; a falling edge transfers the shadow data |
| shadow_i | input | NUM_COLS | Shadow register contents from the loader, bit i for column i |
| frame_i | input | 1 | Frame polarity for the drive waveform |
| blank_ni | input | 1 | Active-low display enable; low forces every column to V5 |
| level_o | output | 2*NUM_COLS | Packed 2-bit level codes, column i at bits 2i+1:2i |

## Verification
The bench builds the block with the default `NUM_COLS` of 240, which is the full line width. At this width the first and last columns are far apart in the packed output, so a single-bit marker in column 0 or column 239 shows any column-to-bit mapping error at either end. The full width also lets alternating and all-ones patterns exercise every code under both frame polarities. The combinational frame and blank paths are checked between clock edges, and captures are checked both with display-enable low and with shadow changes while the pulse is held high.

// File: rtl/lcdlvl_pkg.sv
package lcdlvl_pkg;

   localparam int unsigned CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      LVL_V0 = 2'b00,
      LVL_V2 = 2'b01,
      LVL_V3 = 2'b10,
      LVL_V5 = 2'b11
   } level_e;

   // Level choice for one column from its latched bit, polarity and enable
   function automatic level_e pick_level(input logic bit_q,
                                         input logic frame,
                                         input logic enable_n);
      level_e lvl;
      if (!enable_n)
         lvl = LVL_V5;
      else if (frame)
         lvl = bit_q ? LVL_V0 : LVL_V2;
      else
         lvl = bit_q ? LVL_V5 : LVL_V3;
      return lvl;
   endfunction

endpackage

// File: rtl/lcdlvl_fall_det.sv
module lcdlvl_fall_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pulse_i,
   output logic fall_o
);

   logic pulse_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         pulse_q <= 1'b0;
      else
         pulse_q <= pulse_i;
   end

   assign fall_o = pulse_q & ~pulse_i;

endmodule

// File: rtl/lcdlvl_line_reg.sv
module lcdlvl_line_reg #(
   parameter int unsigned WIDTH = 240
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("lcdlvl_line_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end

endmodule

// File: rtl/lcdlvl_col_enc.sv
module lcdlvl_col_enc
   import lcdlvl_pkg::*;
(
   input  logic              bit_i,
   input  logic              frame_i,
   input  logic              blank_ni,
   output logic [CODE_W-1:0] code_o
);

   level_e lvl;

   always_comb begin
      lvl    = pick_level(bit_i, frame_i, blank_ni);
      code_o = lvl;
   end

endmodule

// File: rtl/lcdlvl_top.sv
module lcdlvl_top
   import lcdlvl_pkg::*;
#(
   parameter int unsigned NUM_COLS = 240
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       lp_i,
   input  logic [NUM_COLS-1:0]        shadow_i,
   input  logic                       frame_i,
   input  logic                       blank_ni,
   output logic [CODE_W*NUM_COLS-1:0] level_o
);

   localparam int unsigned OUT_W = CODE_W * NUM_COLS;

   generate
      if (NUM_COLS < 1) begin : g_bad_cols
         $error("lcdlvl_top: NUM_COLS must be at least 1");
      end
      if (OUT_W != CODE_W * NUM_COLS) begin : g_bad_outw
         $error("lcdlvl_top: output width mismatch");
      end
   endgenerate

   logic                lp_fall;
   logic [NUM_COLS-1:0] line_q;

   lcdlvl_fall_det u_fall (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (lp_i),
      .fall_o  (lp_fall)
   );

   lcdlvl_line_reg #(
      .WIDTH (NUM_COLS)
   ) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (lp_fall),
      .d_i    (shadow_i),
      .q_o    (line_q)
   );

   generate
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
         lcdlvl_col_enc u_enc (
            .bit_i    (line_q[c]),
            .frame_i  (frame_i),
            .blank_ni (blank_ni),
            .code_o   (level_o[CODE_W*c +: CODE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/lcdlvl_chk.sv
module lcdlvl_chk #(
   parameter int unsigned NUM_COLS = 240
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  lp_i,
   input logic [NUM_COLS-1:0]   shadow_i,
   input logic                  frame_i,
   input logic                  blank_ni,
   input logic [NUM_COLS-1:0]   line_q,
   input logic [2*NUM_COLS-1:0] level_o
);

   logic                lp_seen;
   logic [NUM_COLS-1:0] hi_bits;
   logic [NUM_COLS-1:0] lo_bits;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) lp_seen <= 1'b0;
      else         lp_seen <= lp_i;
   end

   always_comb begin
      for (int c = 0; c < NUM_COLS; c++) begin
         hi_bits[c] = level_o[2*c+1];
         lo_bits[c] = level_o[2*c];
      end
   end

   // R1: a sampled falling pulse loads the whole shadow word
   p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lp_seen && !lp_i) |=> (line_q == $past(shadow_i)));

   // R2: without a falling pulse the line register holds
   p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lp_seen && !lp_i) |=> $stable(line_q));

   // R3: positive frame keeps every code in the upper pair
   p_frame_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_ni && frame_i) |-> (hi_bits == '0 && lo_bits == ~line_q));

   // R4: negative frame keeps every code in the lower pair
   p_frame_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_ni && !frame_i) |-> (hi_bits == '1 && lo_bits == line_q));

   // R5: display disabled forces the lowest level everywhere
   p_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blank_ni |-> (level_o == '1));

endmodule

bind lcdlvl_top lcdlvl_chk #(.NUM_COLS(NUM_COLS)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .lp_i     (lp_i),
   .shadow_i (shadow_i),
   .frame_i  (frame_i),
   .blank_ni (blank_ni),
   .line_q   (line_q),
   .level_o  (level_o)
);

// File: tb/lcdlvl_top_tb.sv
module lcdlvl_top_tb_top;

   localparam int unsigned N  = 240;
   localparam int unsigned OW = 2 * N;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          lp_i = 1'b0;
   logic [N-1:0]  shadow_i = '0;
   logic          frame_i = 1'b1;
   logic          blank_ni = 1'b1;
   logic [OW-1:0] level_o;

   int checks = 0;
   int fails  = 0;
   logic [N-1:0] model_line = '0;

   always #10 clk_i = ~clk_i;

   lcdlvl_top #(.NUM_COLS(N)) dut_i (
      .clk_i, .rst_ni, .lp_i, .shadow_i, .frame_i, .blank_ni, .level_o
   );

   function automatic logic [OW-1:0] expect_codes(logic [N-1:0] ln, logic fr, logic en_n);
      logic [OW-1:0] v;
      for (int c = 0; c < N; c++) begin
         if (!en_n)   v[2*c +: 2] = 2'b11;
         else if (fr) v[2*c +: 2] = ln[c] ? 2'b00 : 2'b01;
         else         v[2*c +: 2] = ln[c] ? 2'b11 : 2'b10;
      end
      return v;
   endfunction

   task automatic check(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_now(string req);
      check(req, level_o, expect_codes(model_line, frame_i, blank_ni));
   endtask

   // Drive a high then low latch pulse; capture happens at the second edge
   task automatic latch_line(logic [N-1:0] data);
      @(negedge clk_i); lp_i = 1'b1; shadow_i = data;
      @(negedge clk_i); lp_i = 1'b0;
      @(negedge clk_i); model_line = data;
   endtask

   task automatic t_reset();
      frame_i = 1'b1; blank_ni = 1'b1; shadow_i = '1; lp_i = 1'b1;
      repeat (3) @(negedge clk_i);
      check("R7 reset clear, frame high", level_o, {N{2'b01}});
      frame_i = 1'b0; #1;
      check("R7 reset clear, frame low", level_o, {N{2'b10}});
      rst_ni = 1'b1; lp_i = 1'b0;
      @(negedge clk_i); frame_i = 1'b1;
   endtask

   task automatic t_capture();
      latch_line({(N/2){2'b01}});
      check_now("R1 capture alternating");
      check_now("R3 frame high mapping");
      frame_i = 1'b0; #1;
      check_now("R4 frame low mapping");
      frame_i = 1'b1;
      latch_line('1);
      check("R3 all ones frame high", level_o, {N{2'b00}});
   endtask

   task automatic t_hold();
      @(negedge clk_i); shadow_i = '0;
      repeat (3) @(negedge clk_i);
      check_now("R2 lp low, shadow change ignored");
      lp_i = 1'b1;
      repeat (2) @(negedge clk_i);
      check_now("R2 rising lp ignored");
      shadow_i = {(N/2){2'b10}};
      @(negedge clk_i);
      check_now("R2 lp held high ignored");
      shadow_i = {(N/2){2'b01}};
      lp_i = 1'b0;
      @(negedge clk_i); model_line = {(N/2){2'b01}};
      check_now("R1 value present at falling edge taken");
   endtask

   task automatic t_edges();
      logic [N-1:0] first = '0;
      logic [N-1:0] last = '0;
      first[0] = 1'b1; last[N-1] = 1'b1;
      latch_line(first);
      check("R8 column 0 mapping", level_o, {{(N-1){2'b01}}, 2'b00});
      latch_line(last);
      frame_i = 1'b0; #1;
      check("R8 last column mapping", level_o, {2'b11, {(N-1){2'b10}}});
      frame_i = 1'b1;
   endtask

   task automatic t_blank();
      @(negedge clk_i); blank_ni = 1'b0; #1;
      check("R5 blank, frame high", level_o, '1);
      frame_i = 1'b0; #1;
      check("R5 blank, frame low", level_o, '1);
      latch_line({(N/2){2'b10}});
      check("R5 blank during capture", level_o, '1);
      blank_ni = 1'b1; #1;
      check_now("R6 capture under blank kept");
      frame_i = 1'b1;
   endtask

   task automatic t_comb();
      @(negedge clk_i); #2;
      frame_i = 1'b0; #1;
      check_now("R6 frame change without clock");
      blank_ni = 1'b0; #1;
      check_now("R6 blank change without clock");
      blank_ni = 1'b1; frame_i = 1'b1; #1;
      check_now("R6 restore after release");
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_capture();
      t_hold();
      t_edges();
      t_blank();
      t_comb();
      repeat (2) @(negedge clk_i);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule